// File: doc/BRIEF.md
# Split-Bus Static RAM Model

This block is a synthesizable, cycle-based model of an asynchronous static RAM whose data input and data output run on separate buses. It serves as the target memory in a bench for a memory controller. The bench drives an 18-bit address, a 4-bit input word, an active-low select and an active-low write strobe. The model returns a 4-bit output word and a per-bit drive flag that stands in for three-state output pins: a flag of 0 means the pin floats.

A write is open for as long as select and write strobe are both low. The model samples the pins on a fast simulation clock. When it sees the open-write condition drop, it stores the input word held on the last sample where the write was still open, at the address held on that sample. A parameter picks what the outputs do while a write is open. In echo mode they drive the input word. In quiet mode they float for the whole write. The depth is a parameter so that the model stays small, and the address port keeps its full width.

Top module: `sio_sram`

## Requirements
- R1: While select (`sel_n`) is high, every bit of `q_oe` is 0 and `q` reads 0, whatever the other inputs do.
- R2: While `sel_n` is low and `wr_n` is high, `q_oe` is all ones and `q` shows the word stored at the addressed location, in the same cycle.
- R3: A write stores the `d` value from the last clock sample on which `sel_n` and `wr_n` were both low, at the address from that sample. A change of `d` after the write has closed has no effect on the stored word.
- R4: With `ECHO_WRITE`=0, `q_oe` is 0 in every cycle where `sel_n` and `wr_n` are both low.
- R5: With `ECHO_WRITE`=1, `q_oe` is all ones and `q` equals `d` in every cycle where `sel_n` and `wr_n` are both low.
- R6: A write may be closed by raising either `wr_n` or `sel_n`, whichever rises first, and both ways store the word.
- R7: With `ECHO_WRITE`=0, if `sel_n` and `wr_n` rise in the same cycle, `q_oe` stays 0 through that cycle and the next, and the word is still stored.
- R8: Only the low `DEPTH_LOG` address bits select a word. Addresses that differ only above them reach the same word.
- R9: A read of the just-written address, in the cycle right after the write closes, returns the new word.
- R10: After reset, with `sel_n` high, the outputs float and no write is stored until a new write has opened and closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Simulation sampling clock |
| rst_n | input | 1 | Active-low reset of the write-tracking state |
| addr | input | 18 | Word address |
| d | input | 4 | Input data word |
| sel_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe |
| q | output | 4 | Output data word |
| q_oe | output | 4 | Per-bit output drive flag (0 = floating) |

## Verification
The output word and the drive flags are combinational from the pins and the array, so every read, float and echo result is due in the same cycle as the stimulus. The bench drives pins on the falling clock edge and samples one time unit later. A closed write reaches the array on the first rising edge after the close, and the read in the gap cycle before that edge is served by a forward path. The bench therefore checks that gap cycle right after the close, then reads again two falling edges later, when the array already holds the word. The late change of `d` is made in the closing cycle, so the store of the earlier sample is what the later read shows.

// File: rtl/sio_sram.sv
module sio_sram #(
  parameter int ADDR_W     = 18,
  parameter int DATA_W     = 4,
  parameter int DEPTH_LOG  = 10,
  parameter bit ECHO_WRITE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] d,
  input  logic              sel_n,
  input  logic              wr_n,
  output logic [DATA_W-1:0] q,
  output logic [DATA_W-1:0] q_oe
);
  localparam int DEPTH = 1 << DEPTH_LOG;
  localparam logic [ADDR_W-1:0] IDX_MASK = ADDR_W'((64'd1 << DEPTH_LOG) - 64'd1);

  logic [DATA_W-1:0]    mem [DEPTH];
  logic [DEPTH_LOG-1:0] idx, idx_q;
  logic [DATA_W-1:0]    d_q, rd_word;
  logic                 wr_open, wr_open_q, wr_close, rd_open, drive;

  assign idx      = addr[DEPTH_LOG-1:0];
  assign wr_open  = !sel_n && !wr_n;
  assign rd_open  = !sel_n && wr_n;
  assign wr_close = wr_open_q && !wr_open;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_open_q <= 1'b0;
      idx_q     <= '0;
      d_q       <= '0;
    end else begin
      wr_open_q <= wr_open;
      if (wr_open) begin
        idx_q <= idx;
        d_q   <= d;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && wr_close) mem[idx_q] <= d_q;
  end

  assign rd_word = (wr_close && idx == idx_q) ? d_q : mem[idx];

  always_comb begin
    drive = 1'b0;
    q     = '0;
    if (rd_open) begin
      drive = 1'b1;
      q     = rd_word;
    end else if (wr_open && ECHO_WRITE) begin
      drive = 1'b1;
      q     = d;
    end
  end
  assign q_oe = {DATA_W{drive}};

  p_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_open_q && !wr_open) |=> mem[$past(idx_q)] == $past(d_q));

  p_float_desel_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |-> (q_oe == '0 && q == '0));

  p_quiet_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ECHO_WRITE && !sel_n && !wr_n) |-> q_oe == '0);

  p_echo_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ECHO_WRITE && !sel_n && !wr_n) |-> (q == d && &q_oe));

  p_no_glitch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ECHO_WRITE && $past(!sel_n && !wr_n) && sel_n && wr_n) |-> q_oe == '0);

  p_alias_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_open && $past(rd_open) && !$past(wr_close) &&
     (addr & IDX_MASK) == ($past(addr) & IDX_MASK)) |-> $stable(q));

  p_flags_uniform_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (q_oe == '0) || (&q_oe));
endmodule

// File: tb/sio_sram_tb.sv
module sio_sram_tb;
  localparam int CLK_P = 10;
  localparam int DL    = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [17:0] addr = '0;
  logic [3:0]  d = '0;
  logic sel_n = 1'b1, wr_n = 1'b1;
  logic [3:0] qs, oes, qt, oet;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  sio_sram #(.ADDR_W(18), .DATA_W(4), .DEPTH_LOG(DL), .ECHO_WRITE(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .d(d), .sel_n(sel_n), .wr_n(wr_n),
    .q(qs), .q_oe(oes));
  sio_sram #(.ADDR_W(18), .DATA_W(4), .DEPTH_LOG(DL), .ECHO_WRITE(1'b1)) u_dut_echo (
    .clk(clk), .rst_n(rst_n), .addr(addr), .d(d), .sel_n(sel_n), .wr_n(wr_n),
    .q(qt), .q_oe(oet));

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk); sel_n = 1'b1; wr_n = 1'b1; d = 4'h0;
  endtask

  task automatic rd(input logic [17:0] a, input logic [3:0] e, input string tag);
    @(negedge clk); addr = a; sel_n = 1'b0; wr_n = 1'b1; #1;
    chk({tag, " q quiet"}, {4'h0, qs}, {4'h0, e});
    chk({tag, " oe quiet"}, {4'h0, oes}, 8'h0F);
    chk({tag, " q echo"}, {4'h0, qt}, {4'h0, e});
  endtask

  // open a write, close it by wr_n, sel_n or both; d changes right after close
  task automatic wr(input logic [17:0] a, input logic [3:0] v, input int how);
    @(negedge clk); addr = a; d = v; sel_n = 1'b0; wr_n = 1'b0; #1;
    chk("R4 quiet float in write", {4'h0, oes}, 8'h00);
    chk("R5 echo drive", {oet, qt}, {4'hF, v});
    @(negedge clk);
    if (how == 0) wr_n = 1'b1;
    else if (how == 1) sel_n = 1'b1;
    else begin sel_n = 1'b1; wr_n = 1'b1; end
    d = ~v;
  endtask

  task automatic t_reset();
    #1; chk("R10 float in reset", {oes, oet}, 8'h00);
    repeat (3) @(negedge clk);
    rst_n = 1'b1; #1;
    chk("R1 R10 float after reset", {oes, oet}, 8'h00);
    chk("R1 q zero", {qs, qt}, 8'h00);
  endtask

  task automatic t_desel();
    @(negedge clk); addr = 18'h3; d = 4'hA; sel_n = 1'b1; wr_n = 1'b0; #1;
    chk("R1 deselected with wr_n low", {oes, oet}, 8'h00);
    idle();
  endtask

  task automatic t_wr_by_strobe();
    wr(18'h010, 4'h5, 0);
    #1; chk("R9 forward read", {4'h0, qs}, 8'h05);
    idle();
    rd(18'h010, 4'h5, "R3 R6 strobe close");
    idle();
  endtask

  task automatic t_wr_by_select();
    wr(18'h011, 4'hC, 1);
    #1; chk("R1 float after select close", {oes, oet}, 8'h00);
    idle();
    rd(18'h011, 4'hC, "R6 select close");
    rd(18'h010, 4'h5, "R2 R3 neighbour untouched");
    idle();
  endtask

  task automatic t_both_rise();
    wr(18'h020, 4'h9, 2);
    #1; chk("R7 no glitch", {4'h0, oes}, 8'h00);
    @(negedge clk); #1;
    chk("R7 still floating", {4'h0, oes}, 8'h00);
    rd(18'h020, 4'h9, "R7 stored");
    idle();
  endtask

  task automatic t_alias();
    wr(18'h00005 | (18'h1 << DL) | (18'h1 << 17), 4'h3, 0);
    idle();
    rd(18'h00005, 4'h3, "R8 alias low");
    rd(18'h00005 | (18'h3 << DL), 4'h3, "R8 alias high");
    idle();
  endtask

  task automatic t_no_spurious();
    @(negedge clk); addr = 18'h010; d = 4'hE; sel_n = 1'b0; wr_n = 1'b1;
    @(negedge clk); sel_n = 1'b1;
    idle();
    rd(18'h010, 4'h5, "R3 R10 read does not store");
    idle();
  endtask

  task automatic t_overwrite();
    wr(18'h030, 4'h1, 0);
    idle();
    wr(18'h030, 4'hF, 1);
    idle();
    rd(18'h030, 4'hF, "R3 overwrite");
    idle();
  endtask

  initial begin
    #(CLK_P * 5000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: got=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_desel();
    t_wr_by_strobe();
    t_wr_by_select();
    t_both_rise();
    t_alias();
    t_no_spurious();
    t_overwrite();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule